// File: doc/BRIEF.md
# Single-Channel Memory-Copy DMA Engine

This block copies a run of bytes from one place in memory to another. Software drives it through a 32-bit register port. It first takes ownership of the channel with the claim bit. It then programs three 64-bit registers: a byte count, a destination address and a source address. Each of these is written as two independent 32-bit words. After that it selects the read and write beat sizes. Writing the control word with both the claim bit and the run bit set starts the copy. Writes to the register port take effect on the clock edge, and read data comes back combinationally from `reg_addr`.

The copy loop drives a simple memory master with one transaction outstanding at a time. Each beat is a read of 2^rsize bytes at the source, followed by a write of 2^wsize bytes at the destination. The write carries the read data unchanged in its low lanes. After each beat, both working addresses advance by the write beat size and the remaining count falls by the same amount. When the loop ends, the run bit drops and a done flag is raised, while the claim bit stays set.

The engine state machine has five states:
- IDLE: waiting for a start.
- RD_REQ: read request presented.
- RD_WAIT: waiting for read data.
- WR_REQ: write request presented.
- FINISH: a one-cycle completion pulse.

It has these transitions:
- IDLE to FINISH on a start with a zero count.
- IDLE to RD_REQ on a start with a nonzero count.
- RD_REQ to RD_WAIT when the request is accepted.
- RD_WAIT to WR_REQ when the response arrives.
- WR_REQ to RD_REQ on acceptance while more than one beat remains.
- WR_REQ to FINISH on acceptance of the last beat.
- FINISH to IDLE, unconditionally.

Top module: `memcopy_dma`

## Requirements
- R1: The control word is at offset 0x00. It reads back as claim in bit 0, run in bit 1, done in bit 30, and zero elsewhere. It is 0 after reset. Writing it sets claim to bit 0 of the written data.
- R2: A control write with bits 0 and 1 both set, made while idle, sets claim and run and starts a copy. A write with bit 1 set and bit 0 clear leaves run at 0 and makes no memory access.
- R3: When a copy ends, run clears, done sets and claim stays 1, so the control word reads 0x40000001.
- R4: The count (0x08 low, 0x0C high), the destination (0x10 low, 0x14 high) and the source (0x18 low, 0x1C high) are each split into two 32-bit words. Each word reads back its last written value, and writing one word never changes the other.
- R5: The size word is at 0x04. Bits 31:28 hold the write size and bits 27:24 hold the read size, each as a log2 byte count. All other bits read 0. A stored size above 3 acts as 3 (8 bytes).
- R6: Each beat issues one read of the current source address with size rsize. When its response arrives, the beat issues one write of the current destination address with size wsize, carrying the read data. The source memory is left unchanged.
- R7: After each accepted write, both addresses advance by 2^wsize. If the remaining count is at most 2^wsize, that write is the last one; otherwise the count falls by 2^wsize.
- R8: If a start occurs with a zero count, done reads 1 on the cycle after the start write and no memory request is issued.
- R9: While run is 1, writes to every register, the control word included, are ignored.
- R10: A start clears a previous done flag. A control write with bit 0 clear clears both claim and done.
- R11: A memory request that is not accepted keeps valid, address, write-enable and size unchanged until it is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_addr | output | 64 | Memory byte address |
| mem_req_we | output | 1 | 1 for write, 0 for read |
| mem_req_wdata | output | 64 | Write data, low lanes used |
| mem_req_size | output | 2 | log2 of the beat bytes |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_rdata | input | 64 | Read response data |

## Verification
The assertions take for granted that the memory side sends a read response only while the engine waits for one, and that it sends exactly one response per accepted read. The bench memory model meets this by raising its response valid for exactly one cycle, on the cycle after it accepts a read. It also holds its ready low only through a bench-controlled stall, which lets requests wait without ever sending unsolicited data. Register writes during a run are driven on purpose, because the design must ignore them.

// File: rtl/memcopy_dma_pkg.sv
`timescale 1ns/1ps
package memcopy_dma_pkg;
    localparam int REG_W    = 32;
    localparam int REG_AW   = 6;
    localparam int ADDR_W   = 64;
    localparam int DATA_W   = 64;
    localparam int SIZE_W   = 2;
    localparam int MAX_SIZE = 3;
    localparam int N_WIDE   = 3;
    localparam int N_HALF   = 2 * N_WIDE;

    localparam logic [REG_AW-1:0] OFS_CTRL = 6'h00;
    localparam logic [REG_AW-1:0] OFS_CFG  = 6'h04;
    localparam logic [REG_AW-1:0] OFS_CNT  = 6'h08;
    localparam logic [REG_AW-1:0] OFS_DST  = 6'h10;
    localparam logic [REG_AW-1:0] OFS_SRC  = 6'h18;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_WR_REQ,
        ST_FINISH
    } dma_state_e;

    function automatic logic [SIZE_W-1:0] clamp_size(input logic [3:0] s);
        return (s > 4'(MAX_SIZE)) ? SIZE_W'(MAX_SIZE) : s[SIZE_W-1:0];
    endfunction
endpackage

// File: rtl/memcopy_dma_regs.sv
`timescale 1ns/1ps
module memcopy_dma_regs
    import memcopy_dma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    input  logic              fin_i,
    output logic              start_o,
    output logic [ADDR_W-1:0] cnt_o,
    output logic [ADDR_W-1:0] dst_o,
    output logic [ADDR_W-1:0] src_o,
    output logic [3:0]        rsize_o,
    output logic [3:0]        wsize_o
);
    logic       claim_q, run_q, done_q;
    logic [3:0] wsz_q, rsz_q;
    logic       wr_ok;
    logic [REG_W-1:0] half_w [N_HALF];
    logic [2:0] idx;

    // writes are accepted only while no copy is running
    assign wr_ok   = wr_en && !run_q;
    assign start_o = wr_ok && (addr == OFS_CTRL) && wdata[0] && wdata[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            claim_q <= 1'b0;
            run_q   <= 1'b0;
            done_q  <= 1'b0;
        end else if (fin_i) begin
            run_q  <= 1'b0;
            done_q <= 1'b1;
        end else if (start_o) begin
            claim_q <= 1'b1;
            run_q   <= 1'b1;
            done_q  <= 1'b0;
        end else if (wr_ok && addr == OFS_CTRL) begin
            claim_q <= wdata[0];
            if (!wdata[0]) done_q <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wsz_q <= '0;
            rsz_q <= '0;
        end else if (wr_ok && addr == OFS_CFG) begin
            wsz_q <= wdata[31:28];
            rsz_q <= wdata[27:24];
        end
    end

    // six independent 32-bit words: count, destination, source (low, high)
    for (genvar k = 0; k < N_HALF; k++) begin : g_half
        localparam logic [REG_AW-1:0] MY_OFS = REG_AW'(8 + 4 * k);
        logic [REG_W-1:0] word_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          word_q <= '0;
            else if (wr_ok && addr == MY_OFS)    word_q <= wdata;
        end
        assign half_w[k] = word_q;
    end

    assign cnt_o   = {half_w[1], half_w[0]};
    assign dst_o   = {half_w[3], half_w[2]};
    assign src_o   = {half_w[5], half_w[4]};
    assign rsize_o = rsz_q;
    assign wsize_o = wsz_q;

    assign idx = addr[4:2] - 3'd2;

    always_comb begin
        rdata = '0;
        if (addr == OFS_CTRL)
            rdata = {1'b0, done_q, 28'b0, run_q, claim_q};
        else if (addr == OFS_CFG)
            rdata = {wsz_q, rsz_q, 24'b0};
        else if (!addr[5] && addr[1:0] == 2'b00 && addr[4:3] != 2'b00)
            rdata = half_w[idx];
    end

    p_run_needs_claim_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> claim_q);

    p_done_keeps_claim_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> (claim_q && !run_q));

    p_half_independent_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_DST) |=> $stable(dst_o[63:32]));

    p_zero_count_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_o && cnt_o == '0) |=> ##1 done_q);

    p_frozen_while_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && wr_en) |=> ($stable(cnt_o) && $stable(dst_o) && $stable(src_o)
                              && $stable(rsz_q) && $stable(wsz_q) && $stable(claim_q)));
endmodule

// File: rtl/memcopy_dma_engine.sv
`timescale 1ns/1ps
module memcopy_dma_engine
    import memcopy_dma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] cnt_i,
    input  logic [ADDR_W-1:0] dst_i,
    input  logic [ADDR_W-1:0] src_i,
    input  logic [3:0]        rsize_i,
    input  logic [3:0]        wsize_i,
    output logic              fin_o,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic              mem_req_we,
    output logic [DATA_W-1:0] mem_req_wdata,
    output logic [SIZE_W-1:0] mem_req_size,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_rdata
);
    dma_state_e state_q, state_d;
    logic [ADDR_W-1:0] rem_q, rd_addr_q, wr_addr_q, step;
    logic [DATA_W-1:0] data_q;
    logic [SIZE_W-1:0] rsz_q, wsz_q;
    logic              last_beat;

    assign step      = ADDR_W'(1) << wsz_q;
    assign last_beat = (rem_q <= step);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_i) state_d = (cnt_i == '0) ? ST_FINISH : ST_RD_REQ;
            ST_RD_REQ:  if (mem_req_ready) state_d = ST_RD_WAIT;
            ST_RD_WAIT: if (mem_rsp_valid) state_d = ST_WR_REQ;
            ST_WR_REQ:  if (mem_req_ready) state_d = last_beat ? ST_FINISH : ST_RD_REQ;
            ST_FINISH:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q     <= '0;
            rd_addr_q <= '0;
            wr_addr_q <= '0;
            data_q    <= '0;
            rsz_q     <= '0;
            wsz_q     <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (start_i) begin
                    rem_q     <= cnt_i;
                    rd_addr_q <= src_i;
                    wr_addr_q <= dst_i;
                    rsz_q     <= clamp_size(rsize_i);
                    wsz_q     <= clamp_size(wsize_i);
                end
                ST_RD_WAIT: if (mem_rsp_valid) data_q <= mem_rsp_rdata;
                ST_WR_REQ: if (mem_req_ready) begin
                    if (last_beat) rem_q <= '0;
                    else begin
                        rem_q     <= rem_q - step;
                        rd_addr_q <= rd_addr_q + step;
                        wr_addr_q <= wr_addr_q + step;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        mem_req_valid = (state_q == ST_RD_REQ) || (state_q == ST_WR_REQ);
        mem_req_we    = (state_q == ST_WR_REQ);
        mem_req_addr  = mem_req_we ? wr_addr_q : rd_addr_q;
        mem_req_size  = mem_req_we ? wsz_q : rsz_q;
        mem_req_wdata = data_q;
        fin_o         = (state_q == ST_FINISH);
    end

    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we) && $stable(mem_req_size)));

    p_rsp_only_when_waiting_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rsp_valid |-> (state_q == ST_RD_WAIT));

    p_write_follows_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rsp_valid && state_q == ST_RD_WAIT) |=> (mem_req_valid && mem_req_we));
endmodule

// File: rtl/memcopy_dma.sv
`timescale 1ns/1ps
module memcopy_dma
    import memcopy_dma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic              mem_req_we,
    output logic [DATA_W-1:0] mem_req_wdata,
    output logic [SIZE_W-1:0] mem_req_size,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_rdata
);
    logic              start, fin;
    logic [ADDR_W-1:0] cnt, dst, src;
    logic [3:0]        rsize, wsize;

    memcopy_dma_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .fin_i   (fin),
        .start_o (start),
        .cnt_o   (cnt),
        .dst_o   (dst),
        .src_o   (src),
        .rsize_o (rsize),
        .wsize_o (wsize)
    );

    memcopy_dma_engine u_engine (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start),
        .cnt_i         (cnt),
        .dst_i         (dst),
        .src_i         (src),
        .rsize_i       (rsize),
        .wsize_i       (wsize),
        .fin_o         (fin),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_req_we    (mem_req_we),
        .mem_req_wdata (mem_req_wdata),
        .mem_req_size  (mem_req_size),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_rdata (mem_rsp_rdata)
    );
endmodule

// File: tb/memcopy_dma_bench.sv
`timescale 1ns/1ps
module memcopy_dma_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req_valid, mem_req_we;
    logic        mem_req_ready;
    logic [63:0] mem_req_addr, mem_req_wdata;
    logic [1:0]  mem_req_size;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_rdata = '0;

    logic        stall = 1'b0;
    logic [7:0]  mem [512];
    int          rd_cnt = 0, wr_cnt = 0;
    logic [63:0] last_wr_addr = '0;
    logic [1:0]  last_rd_size = '0, last_wr_size = '0;
    int          checks = 0, errors = 0;

    always #2.5 clk = ~clk;
    assign mem_req_ready = !stall;

    memcopy_dma u_memcopy_dma (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_req_we(mem_req_we),
        .mem_req_wdata(mem_req_wdata), .mem_req_size(mem_req_size),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
    );

    // memory model: 512 bytes, indexed by the low 9 address bits
    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        if (mem_req_valid && mem_req_ready) begin
            if (mem_req_we) begin
                for (int b = 0; b < 8; b++)
                    if (b < (1 << mem_req_size))
                        mem[9'(mem_req_addr[8:0] + 9'(b))] = mem_req_wdata[8*b +: 8];
                wr_cnt       <= wr_cnt + 1;
                last_wr_addr <= mem_req_addr;
                last_wr_size <= mem_req_size;
            end else begin
                logic [63:0] d;
                for (int b = 0; b < 8; b++)
                    d[8*b +: 8] = mem[9'(mem_req_addr[8:0] + 9'(b))];
                mem_rsp_rdata <= d;
                mem_rsp_valid <= 1'b1;
                rd_cnt        <= rd_cnt + 1;
                last_rd_size  <= mem_req_size;
            end
        end
    end

    task automatic put32(input int a, input logic [31:0] d);
        for (int b = 0; b < 4; b++) mem[a + b] = d[8*b +: 8];
    endtask

    function automatic logic [31:0] get32(input int a);
        logic [31:0] r;
        for (int b = 0; b < 4; b++) r[8*b +: 8] = mem[a + b];
        return r;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_done();
        logic [31:0] v;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            rd(6'h00, v);
            if (v[30]) break;
        end
    endtask

    // {offset, write data, expected readback}
    localparam logic [95:0] VEC [8] = '{
        {32'h08, 32'h0000_0004, 32'h0000_0004},
        {32'h0C, 32'h0000_0000, 32'h0000_0000},
        {32'h10, 32'h8000_0000, 32'h8000_0000},
        {32'h14, 32'h0000_0002, 32'h0000_0002},
        {32'h18, 32'h8000_0100, 32'h8000_0100},
        {32'h1C, 32'h0000_0002, 32'h0000_0002},
        {32'h04, 32'hFFFF_FFFF, 32'hFF00_0000},
        {32'h04, 32'h2200_0000, 32'h2200_0000}
    };

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int r0, w0;
        for (int i = 0; i < 512; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        rd(6'h00, v); chk("R1 reset control", v, 0);
        rd(6'h08, v); chk("R1 reset count low", v, 0);

        for (int i = 0; i < 8; i++) begin
            wr(VEC[i][69:64], VEC[i][63:32]);
            rd(VEC[i][69:64], v);
            chk((VEC[i][69:64] == 6'h04) ? "R5 size readback" : "R4 word readback", v, VEC[i][31:0]);
        end
        for (int i = 0; i < 8; i++) begin
            if (i == 6) continue;
            rd(VEC[i][69:64], v);
            chk("R4 other half undisturbed", v, VEC[i][31:0]);
        end

        wr(6'h00, 32'h2);
        rd(6'h00, v); chk("R2 run without claim", v, 0);
        repeat (3) @(negedge clk);
        chk("R2 no access without claim", rd_cnt + wr_cnt, 0);

        wr(6'h00, 32'h1);
        rd(6'h00, v); chk("R1 claim", v, 32'h1);

        put32(0, 32'h8765_4321);
        put32(9'h100, 32'h1234_5678);
        wr(6'h00, 32'h3);
        rd(6'h00, v); chk("R2 running", v, 32'h3);
        wait_done();
        rd(6'h00, v); chk("R3 completion word", v, 32'h4000_0001);
        chk("R6 destination copied", get32(0), 32'h1234_5678);
        chk("R6 source unchanged", get32(9'h100), 32'h1234_5678);
        chk("R6 one read one write", {rd_cnt[31:0], wr_cnt[31:0]}, {32'd1, 32'd1});
        chk("R6 write address", last_wr_addr, 64'h2_8000_0000);

        r0 = rd_cnt; w0 = wr_cnt;
        wr(6'h08, 32'h0);
        wr(6'h00, 32'h3);
        rd(6'h00, v); chk("R10 start clears done", v, 32'h3);
        @(negedge clk);
        rd(6'h00, v); chk("R8 zero count done next cycle", v, 32'h4000_0001);
        chk("R8 zero count no access", (rd_cnt - r0) + (wr_cnt - w0), 0);

        // two 8-byte beats, held up by a stall to probe R9 and R11
        wr(6'h04, 32'h3300_0000);
        wr(6'h08, 32'd16);
        for (int i = 0; i < 16; i++) mem[9'h100 + i] = 8'(8'hA0 + i);
        stall = 1'b1;
        w0 = wr_cnt;
        wr(6'h00, 32'h3);
        chk("R11 read presented first", {63'(mem_req_addr), mem_req_valid}, {63'h2_8000_0100, 1'b1});
        wr(6'h04, 32'h2200_0000);
        wr(6'h10, 32'h40);
        wr(6'h00, 32'h0);
        rd(6'h04, v); chk("R9 size frozen", v, 32'h3300_0000);
        rd(6'h10, v); chk("R9 destination frozen", v, 32'h8000_0000);
        rd(6'h00, v); chk("R9 control frozen", v, 32'h3);
        chk("R11 request held", {mem_req_valid, mem_req_we, mem_req_addr}, {1'b1, 1'b0, 64'h2_8000_0100});
        stall = 1'b0;
        wait_done();
        chk("R7 two beats", wr_cnt - w0, 2);
        chk("R7 last write address", last_wr_addr, 64'h2_8000_0008);
        chk("R7 first word", get32(0), 32'hA3A2_A1A0);
        chk("R7 last word", get32(12), 32'hAFAE_ADAC);

        wr(6'h04, 32'h2200_0000);
        wr(6'h08, 32'd6);
        w0 = wr_cnt;
        wr(6'h00, 32'h3);
        wait_done();
        chk("R7 short tail beats", wr_cnt - w0, 2);
        chk("R7 short tail address", last_wr_addr, 64'h2_8000_0004);

        wr(6'h04, 32'h2300_0000);
        wr(6'h08, 32'd4);
        wr(6'h00, 32'h3);
        wait_done();
        chk("R6 read size", last_rd_size, 2'd3);
        chk("R6 write size", last_wr_size, 2'd2);

        wr(6'h04, 32'h2F00_0000);
        wr(6'h08, 32'd8);
        w0 = wr_cnt;
        wr(6'h00, 32'h3);
        wait_done();
        chk("R5 oversize read clamps", last_rd_size, 2'd3);

        wr(6'h00, 32'h0);
        rd(6'h00, v); chk("R10 release clears", v, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule